// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block holds a small table of words that is searched by value instead of by position. A search argument and a bit-enable key sit in two registers of their own. When a search is issued, every stored word is compared with the argument at the same time, but only on the bit positions where the key holds a one. Positions where the key is zero are treated as agreeing. The per-word results are captured in a match vector, one bit per word.

After a search, the matching words are drained one at a time. The readout port always presents the lowest-numbered word whose match bit is still set. Each advance strobe retires that bit. A done flag shows when no set match bits remain. Words are filled by index. Every written word becomes valid, and a word that was never written can never match. Any write wipes the match vector, so results never describe a table that has since changed.

Top module: `mask_cam`

## Requirements
- R1: After reset the match vector is all zero, `rd_valid` is 0, `rd_done` is 1, and no word is valid, so even a search with an all-zero key yields an empty match vector.
- R2: A write stores `wr_data` at index `wr_idx` and marks that word valid. A word that has not been written never sets its match bit.
- R3: One clock edge after `search` is sampled high, `match_vec[i]` is 1 exactly when word i is valid and `((word_i ^ arg) & key) == 0`. Here arg and key are the register contents before that edge.
- R4: Bit positions where the key holds 0 do not affect the result. An all-zero key matches every valid word, and an all-one key requires every bit to be equal.
- R5: While the match vector is non-zero, `rd_valid` is 1, `rd_idx` is the lowest index with a set match bit, and `rd_data` is the stored word at that index.
- R6: An `rd_next` pulse while `rd_valid` is 1 clears the lowest set match bit at the next edge and leaves the other bits unchanged. `rd_done` is 1 exactly when the match vector is zero.
- R7: Any write clears the whole match vector at the same edge. If `wr_en` and `search` are both high in one cycle, the write wins and the vector is cleared.
- R8: The argument and key registers change only on `arg_load` and `key_load`. A search in the same cycle as a load uses the previous register value.
- R9: If `search` and `rd_next` are both high in one cycle, the search result is loaded and the advance is dropped.
- R10: An `rd_next` pulse while the match vector is zero has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arg_load | input | 1 | Load `arg_in` into the argument register |
| arg_in | input | WIDTH | Search argument value |
| key_load | input | 1 | Load `key_in` into the key register |
| key_in | input | WIDTH | Compare enable per bit position (1 = compared) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDXW | Word index to write |
| wr_data | input | WIDTH | Data to write |
| search | input | 1 | Start a parallel masked search |
| rd_next | input | 1 | Retire the currently presented match |
| rd_valid | output | 1 | A set match bit remains |
| rd_idx | output | IDXW | Lowest index with a set match bit |
| rd_data | output | WIDTH | Stored word at `rd_idx` |
| rd_done | output | 1 | Match vector is empty |
| match_vec | output | WORDS | Current match vector |

## Verification
Writes, searches, register loads and readout advances each take effect at the first rising edge after they are sampled. The readout outputs and the done flag follow the match vector without any further register in between. The bench changes every input on the falling edge and holds it through exactly one rising edge. It then compares the ports at the following falling edge, so each result is checked in the first cycle it is due. The expected vectors come from a model of the table kept in the bench. A full readout follows every search, and each step is checked before the next advance is issued.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

    localparam int DEF_WORDS = 8;
    localparam int DEF_WIDTH = 8;

    // action applied to the match vector on a clock edge
    typedef enum logic [1:0] {
        MOP_HOLD  = 2'd0,
        MOP_CLEAR = 2'd1,
        MOP_LOAD  = 2'd2,
        MOP_POP   = 2'd3
    } match_op_e;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // write beats search, search beats advance, advance needs a pending bit
    function automatic match_op_e pick_op(input logic wr, input logic srch,
                                          input logic adv, input logic any);
        if (wr)
            return MOP_CLEAR;
        else if (srch)
            return MOP_LOAD;
        else if (adv && any)
            return MOP_POP;
        else
            return MOP_HOLD;
    endfunction

endpackage

// File: rtl/mcam_store.sv
module mcam_store #(
    parameter int WORDS = mcam_pkg::DEF_WORDS,
    parameter int WIDTH = mcam_pkg::DEF_WIDTH,
    parameter int IDXW  = mcam_pkg::idx_bits(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDXW-1:0]        wr_idx,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [IDXW-1:0]        rd_idx,
    output logic [WORDS*WIDTH-1:0] words_flat,
    output logic [WORDS-1:0]       valid,
    output logic [WIDTH-1:0]       rd_word
);

    logic [WIDTH-1:0] cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
                valid[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDXW'(g))) begin
                cells[g] <= wr_data;
                valid[g] <= 1'b1;
            end
        end
        assign words_flat[g*WIDTH +: WIDTH] = cells[g];
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < WORDS; i++)
            if (rd_idx == IDXW'(i))
                rd_word = cells[i];
    end

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) < WORDS)) |=> valid[$past(wr_idx)]) // R2
        else $error("write did not mark word valid");

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((valid & $past(valid)) == $past(valid))) // R2
        else $error("valid flag dropped without reset");

endmodule

// File: rtl/mcam_compare.sv
module mcam_compare #(
    parameter int WORDS = mcam_pkg::DEF_WORDS,
    parameter int WIDTH = mcam_pkg::DEF_WIDTH
) (
    input  logic [WORDS*WIDTH-1:0] words_flat,
    input  logic [WORDS-1:0]       valid,
    input  logic [WIDTH-1:0]       arg,
    input  logic [WIDTH-1:0]       key,
    output logic [WORDS-1:0]       hits
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WIDTH-1:0] bit_ok;
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            // a disabled position always agrees
            assign bit_ok[b] = ~key[b] | ~(words_flat[w*WIDTH+b] ^ arg[b]);
        end
        assign hits[w] = valid[w] & (&bit_ok);
    end

endmodule

// File: rtl/mcam_match_reg.sv
module mcam_match_reg
    import mcam_pkg::*;
#(
    parameter int WORDS = DEF_WORDS,
    parameter int IDXW  = idx_bits(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  match_op_e        op,
    input  logic [WORDS-1:0] hits,
    output logic [WORDS-1:0] match_q,
    output logic [IDXW-1:0]  sel_idx,
    output logic             any
);

    always_ff @(posedge clk) begin
        if (rst)
            match_q <= '0;
        else begin
            case (op)
                MOP_CLEAR: match_q <= '0;
                MOP_LOAD:  match_q <= hits;
                MOP_POP:   match_q <= match_q & (match_q - WORDS'(1));
                default:   match_q <= match_q;
            endcase
        end
    end

    assign any = |match_q;

    // scan downward so the lowest set bit is the last one taken
    always_comb begin
        sel_idx = '0;
        for (int i = WORDS - 1; i >= 0; i--)
            if (match_q[i])
                sel_idx = IDXW'(i);
    end

    AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any |-> (match_q[sel_idx] &&
                 ((match_q & ((WORDS'(1) << sel_idx) - WORDS'(1))) == '0))) // R5
        else $error("selected index is not the lowest pending match");

    AST_POP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (op == MOP_POP) |=> ($countones(match_q) == $countones($past(match_q)) - 1
                             && (match_q & ~$past(match_q)) == '0)) // R6
        else $error("advance changed more than one match bit");

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (op == MOP_CLEAR) |=> (match_q == '0)) // R7
        else $error("match vector not cleared");

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op == MOP_HOLD) |=> $stable(match_q)) // R10
        else $error("match vector moved without an action");

endmodule

// File: rtl/mask_cam.sv
module mask_cam
    import mcam_pkg::*;
#(
    parameter int WORDS = DEF_WORDS,
    parameter int WIDTH = DEF_WIDTH,
    parameter int IDXW  = idx_bits(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arg_load,
    input  logic [WIDTH-1:0] arg_in,
    input  logic             key_load,
    input  logic [WIDTH-1:0] key_in,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             search,
    input  logic             rd_next,
    output logic             rd_valid,
    output logic [IDXW-1:0]  rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_done,
    output logic [WORDS-1:0] match_vec
);

    logic [WIDTH-1:0]       arg_q;
    logic [WIDTH-1:0]       key_q;
    logic [WORDS*WIDTH-1:0] words_flat;
    logic [WORDS-1:0]       valid;
    logic [WORDS-1:0]       hits;
    logic [WORDS-1:0]       match_q;
    logic [IDXW-1:0]        sel_idx;
    logic                   any;
    match_op_e              op;

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q <= '0;
            key_q <= '0;
        end else begin
            if (arg_load) arg_q <= arg_in;
            if (key_load) key_q <= key_in;
        end
    end

    assign op = pick_op(wr_en, search, rd_next, any);

    mcam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IDXW(IDXW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (sel_idx),
        .words_flat (words_flat),
        .valid      (valid),
        .rd_word    (rd_data)
    );

    mcam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) u_compare (
        .words_flat (words_flat),
        .valid      (valid),
        .arg        (arg_q),
        .key        (key_q),
        .hits       (hits)
    );

    mcam_match_reg #(.WORDS(WORDS), .IDXW(IDXW)) u_match (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .hits    (hits),
        .match_q (match_q),
        .sel_idx (sel_idx),
        .any     (any)
    );

    assign match_vec = match_q;
    assign rd_valid  = any;
    assign rd_idx    = sel_idx;
    assign rd_done   = ~any;

    AST_INVALID_NEVER_MATCH: assert property (@(posedge clk) disable iff (rst)
        (search && !wr_en) |=> ((match_vec & ~valid) == '0)) // R2
        else $error("unwritten word reported as a match");

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (match_vec == '0 && rd_done)) // R7
        else $error("write left matches pending");

    AST_ARG_HELD: assert property (@(posedge clk) disable iff (rst)
        !arg_load |=> $stable(arg_q)) // R8
        else $error("argument changed without load");

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
        !key_load |=> $stable(key_q)) // R8
        else $error("key changed without load");

    AST_SEARCH_BEATS_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (search && rd_next && !wr_en) |=> (match_vec == $past(hits))) // R9
        else $error("advance disturbed search result");

endmodule

// File: tb/mask_cam_bench.sv
`timescale 1ns/1ps
module mask_cam_bench;

    localparam int WORDS = 8;
    localparam int WIDTH = 8;
    localparam int IDXW  = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arg_load = 1'b0;
    logic [WIDTH-1:0] arg_in = '0;
    logic             key_load = 1'b0;
    logic [WIDTH-1:0] key_in = '0;
    logic             wr_en = 1'b0;
    logic [IDXW-1:0]  wr_idx = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             search = 1'b0;
    logic             rd_next = 1'b0;
    logic             rd_valid;
    logic [IDXW-1:0]  rd_idx;
    logic [WIDTH-1:0] rd_data;
    logic             rd_done;
    logic [WORDS-1:0] match_vec;

    int checks = 0;
    int failures = 0;

    logic [WIDTH-1:0] mdl_word [WORDS];
    logic [WORDS-1:0] mdl_valid = '0;

    always #4 clk = ~clk;

    mask_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u_mask_cam (
        .clk(clk), .rst(rst),
        .arg_load(arg_load), .arg_in(arg_in),
        .key_load(key_load), .key_in(key_in),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .search(search), .rd_next(rd_next),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_done(rd_done), .match_vec(match_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [WORDS-1:0] expect_hits(input logic [WIDTH-1:0] a,
                                                     input logic [WIDTH-1:0] k);
        logic [WORDS-1:0] r = '0;
        for (int i = 0; i < WORDS; i++)
            if (mdl_valid[i] && (((mdl_word[i] ^ a) & k) == '0))
                r[i] = 1'b1;
        return r;
    endfunction

    task automatic write_word(input int idx, input logic [WIDTH-1:0] d);
        wr_en = 1'b1; wr_idx = IDXW'(idx); wr_data = d;
        tick();
        wr_en = 1'b0;
        mdl_word[idx] = d;
        mdl_valid[idx] = 1'b1;
    endtask

    task automatic load_both(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
        arg_in = a; key_in = k; arg_load = 1'b1; key_load = 1'b1;
        tick();
        arg_load = 1'b0; key_load = 1'b0;
    endtask

    task automatic do_search();
        search = 1'b1;
        tick();
        search = 1'b0;
    endtask

    // walk the whole match vector, checking each step against the model
    task automatic drain(input logic [WORDS-1:0] exp_vec);
        logic [WORDS-1:0] left = exp_vec;
        while (left != '0) begin
            int low = 0;
            for (int i = WORDS - 1; i >= 0; i--) if (left[i]) low = i;
            chk("R5 rd_valid", 32'(rd_valid), 32'd1);
            chk("R5 rd_idx lowest", 32'(rd_idx), 32'(low));
            chk("R5 rd_data", 32'(rd_data), 32'(mdl_word[low]));
            rd_next = 1'b1;
            tick();
            rd_next = 1'b0;
            left[low] = 1'b0;
            chk("R6 vector after advance", 32'(match_vec), 32'(left));
        end
        chk("R6 done when empty", 32'(rd_done), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [WIDTH-1:0] keys [8];
        keys[0] = 8'h00; keys[1] = 8'hFF; keys[2] = 8'h0F; keys[3] = 8'hF0;
        keys[4] = 8'h81; keys[5] = 8'h3C; keys[6] = 8'h55; keys[7] = 8'hAA;
        for (int i = 0; i < WORDS; i++) mdl_word[i] = '0;

        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 match empty", 32'(match_vec), 32'd0);
        chk("R1 rd_valid low", 32'(rd_valid), 32'd0);
        chk("R1 done high", 32'(rd_done), 32'd1);
        load_both(8'h00, 8'h00);
        do_search();
        chk("R1 no valid words", 32'(match_vec), 32'd0);

        // R2 fill all but the top word
        for (int i = 0; i < WORDS - 1; i++)
            write_word(i, WIDTH'((i * 37 + 5) & 8'hFF) ^ ((i % 3 == 0) ? 8'h0F : 8'h00));
        do_search();
        chk("R4 zero key hits all valid, R2 unwritten excluded", 32'(match_vec), 32'h7F);
        drain(8'h7F);

        // R10 advance on empty
        rd_next = 1'b1;
        tick();
        rd_next = 1'b0;
        chk("R10 empty advance", 32'(match_vec), 32'd0);
        chk("R10 still done", 32'(rd_done), 32'd1);

        // R7 write clears
        load_both(8'h00, 8'h00);
        do_search();
        chk("R7 precondition", 32'(match_vec), 32'h7F);
        write_word(7, 8'h2A);
        chk("R7 write clears", 32'(match_vec), 32'd0);
        wr_en = 1'b1; wr_idx = 3'd7; wr_data = 8'h2A; search = 1'b1;
        tick();
        wr_en = 1'b0; search = 1'b0;
        chk("R7 write beats search", 32'(match_vec), 32'd0);

        // R3 R4 sweep arguments and keys
        for (int k = 0; k < 8; k++) begin
            for (int a = 0; a < 24 + WORDS; a++) begin
                logic [WIDTH-1:0] av;
                logic [WORDS-1:0] ev;
                av = (a < WORDS) ? mdl_word[a] ^ WIDTH'(a & 1) : WIDTH'((a * 53 + 11) & 8'hFF);
                load_both(av, keys[k]);
                do_search();
                ev = expect_hits(av, keys[k]);
                chk("R3 masked compare", 32'(match_vec), 32'(ev));
                drain(ev);
            end
        end

        // R8 held registers and same-cycle load
        load_both(mdl_word[2], 8'hFF);
        arg_in = 8'h00; key_in = 8'h00;
        do_search();
        chk("R8 held values", 32'(match_vec), 32'(expect_hits(mdl_word[2], 8'hFF)));
        arg_in = mdl_word[5]; arg_load = 1'b1; search = 1'b1;
        tick();
        arg_load = 1'b0; search = 1'b0;
        chk("R8 search uses old arg", 32'(match_vec), 32'(expect_hits(mdl_word[2], 8'hFF)));
        do_search();
        chk("R8 new arg after load", 32'(match_vec), 32'(expect_hits(mdl_word[5], 8'hFF)));

        // R9 search beats advance
        load_both(8'h00, 8'h00);
        search = 1'b1; rd_next = 1'b1;
        tick();
        search = 1'b0; rd_next = 1'b0;
        chk("R9 search wins", 32'(match_vec), 32'hFF);
        drain(8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule